// File: doc/BRIEF.md
# Status-Change Interrupt Controller

This block watches a small set of line-status levels and two elastic-buffer event strobes. It raises an active-low interrupt toward a host whenever a watched level toggles in either direction, or whenever the buffer reports an overflow or an underflow. Each source has a sticky pending bit. The pending bits together form a status word that the host reads to learn which source fired.

The host acknowledges a source with a single write port, the clear/mask word. A write stores the whole word. A 1 in a bit position clears that source's pending bit and keeps the source masked for as long as the bit stays 1. A later write of 0 in that position makes the source live again. The interrupt line is an open-drain style output, so the block only provides a pull-low enable and never drives the line high. The serial host transport and the line-side logic that produces the levels are outside this block.

Top module: `stat_irq_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `psr_o` is all zeros, `irq_pull_o` is 0 and every source is unmasked.
- R2: A 0-to-1 change on `stat_lvl_i[k]` sets `psr_o[k]` (k = 0..4) and raises `irq_pull_o`. Both outputs show the change right after the first rising clock edge that samples the new level.
- R3: A 1-to-0 change on `stat_lvl_i[k]` sets `psr_o[k]` in the same way as R2. Several levels that change in one cycle set all of their bits together.
- R4: A one-cycle pulse on `ovf_stb_i` sets `psr_o[5]`. A one-cycle pulse on `unf_stb_i` sets `psr_o[6]`. Both bits update right after the edge that samples the pulse.
- R5: A write (`host_wr_i` = 1) with `host_wdata_i[b]` = 1 clears `psr_o[b]` after that edge. The write leaves bits written with 0 unchanged. Bit b of `host_wdata_i` maps to the same source as `psr_o[b]`.
- R6: While mask bit b holds 1, level changes or strobes of source b leave `psr_o[b]` at 0 and do not raise `irq_pull_o`.
- R7: Writing 0 to mask bit b re-enables source b. Events that arrived while the source was masked are not remembered, and the next event after the write sets `psr_o[b]` again.
- R8: A pending bit stays set until a write clears it. Clearing one source leaves the other pending bits and the interrupt untouched.
- R9: `irq_pull_o` is 1 exactly when `psr_o` has at least one bit set.
- R10: The levels present while reset is held are taken as the starting reference, so static levels of any value cause no interrupt after reset is released.
- R11: When a write with 1 in bit b and an event of source b fall in the same cycle, the clear wins and `psr_o[b]` reads 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stat_lvl_i | input | 5 | Line-status levels: signal loss, alarm indication, pattern detect, two framing/monitor flags |
| ovf_stb_i | input | 1 | One-cycle elastic-buffer overflow strobe |
| unf_stb_i | input | 1 | One-cycle elastic-buffer underflow strobe |
| host_wr_i | input | 1 | Write strobe for the clear/mask word |
| host_wdata_i | input | 7 | Clear/mask word; 1 clears and masks a source, 0 enables it |
| psr_o | output | 7 | Pending status word, bits 0..4 levels, 5 overflow, 6 underflow |
| irq_pull_o | output | 1 | Pull-low enable for the open-drain interrupt line |

## Verification
The bench drives falling as well as rising level transitions. A design that detected only one edge direction would leave the status word empty after the other. It holds non-zero levels through reset to catch a design that compares against a zeroed reference and fires at release.

It also pulses sources while they are masked and then unmasks them. A design that latched events behind the mask would show a stale pending bit after the unmask. Finally it writes a clear in the same cycle as a fresh event on that source. A design that gave set priority over clear would leave the bit standing and the line pulled low.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  // default source counts: level-watched flags and one-cycle event strobes
  localparam int unsigned DEF_NUM_LVL = 5;
  localparam int unsigned DEF_NUM_EVT = 2;

  // position of the strobe sources after the level sources
  function automatic int unsigned evt_pos(input int unsigned num_lvl,
                                          input int unsigned k);
    return num_lvl + k;
  endfunction
endpackage

// File: rtl/lvl_change_det.sv
module lvl_change_det #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] chg_o
);
  logic [WIDTH-1:0] ref_q;

  // reference loads the live level during reset too, so release is quiet
  always_ff @(posedge clk) begin
    ref_q <= lvl_i;
  end

  assign chg_o = rst ? '0 : (lvl_i ^ ref_q);

  // R2 R3: a level that differs from the last cycle must be flagged
  property p_toggle_flagged_r3;
    @(posedge clk) disable iff (rst)
      (lvl_i != $past(lvl_i)) |-> (chg_o != '0);
  endproperty
  assert property (p_toggle_flagged_r3);

  // R10: steady level yields no change flag
  property p_steady_quiet_r10;
    @(posedge clk) disable iff (rst)
      (lvl_i == $past(lvl_i)) |-> (chg_o == '0);
  endproperty
  assert property (p_steady_quiet_r10);
endmodule

// File: rtl/src_latch.sv
module src_latch (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic pend_o,
  output logic pend_nxt_o,
  output logic live_nxt_o
);
  logic mask_q;
  logic mask_d;
  logic pend_q;
  logic pend_d;

  always_comb begin
    mask_d = mask_q;
    pend_d = pend_q;
    if (wr_i) begin
      mask_d = wbit_i;
    end
    if (wr_i && wbit_i) begin
      pend_d = 1'b0;
    end else if (evt_i && !mask_q) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o     = pend_q;
  assign pend_nxt_o = rst ? 1'b0 : pend_d;
  assign live_nxt_o = rst ? 1'b1 : !mask_d;

  // R11: clear beats a same-cycle event
  property p_clear_wins_r11;
    @(posedge clk) disable iff (rst)
      (wr_i && wbit_i) |=> !pend_q;
  endproperty
  assert property (p_clear_wins_r11);

  // R6: a masked source never becomes pending
  property p_masked_quiet_r6;
    @(posedge clk) disable iff (rst)
      (mask_q && !wr_i) |=> !pend_q;
  endproperty
  assert property (p_masked_quiet_r6);

  // R8: pending holds until cleared
  property p_sticky_r8;
    @(posedge clk) disable iff (rst)
      (pend_q && !(wr_i && wbit_i)) |=> pend_q;
  endproperty
  assert property (p_sticky_r8);

  // R2: an unmasked event without clear sets the bit
  property p_event_sets_r2;
    @(posedge clk) disable iff (rst)
      (evt_i && !mask_q && !wr_i) |=> pend_q;
  endproperty
  assert property (p_event_sets_r2);
endmodule

// File: rtl/irq_drive.sv
module irq_drive #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend_nxt_i,
  input  logic [NUM_SRC-1:0] live_nxt_i,
  output logic               pull_o
);
  logic pull_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_q <= 1'b0;
    end else begin
      pull_q <= |(pend_nxt_i & live_nxt_i);
    end
  end

  assign pull_o = pull_q;
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
#(
  parameter int unsigned NUM_LVL = DEF_NUM_LVL,
  parameter int unsigned NUM_EVT = DEF_NUM_EVT,
  localparam int unsigned NUM_SRC = NUM_LVL + NUM_EVT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] stat_lvl_i,
  input  logic               ovf_stb_i,
  input  logic               unf_stb_i,
  input  logic               host_wr_i,
  input  logic [NUM_SRC-1:0] host_wdata_i,
  output logic [NUM_SRC-1:0] psr_o,
  output logic               irq_pull_o
);
  logic [NUM_LVL-1:0] lvl_chg;
  logic [NUM_SRC-1:0] src_evt;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] pend_nxt;
  logic [NUM_SRC-1:0] live_nxt;
  logic [1:0]         strobes;

  lvl_change_det #(.WIDTH(NUM_LVL)) u_chg (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (stat_lvl_i),
    .chg_o (lvl_chg)
  );

  assign strobes = {unf_stb_i, ovf_stb_i};

  // strobe sources sit above the level sources, overflow first
  always_comb begin
    src_evt = '0;
    src_evt[NUM_LVL-1:0] = lvl_chg;
    for (int unsigned k = 0; k < NUM_EVT; k++) begin
      if (k < 2) begin
        src_evt[evt_pos(NUM_LVL, k)] = strobes[k];
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    src_latch u_lat (
      .clk        (clk),
      .rst        (rst),
      .evt_i      (src_evt[g]),
      .wr_i       (host_wr_i),
      .wbit_i     (host_wdata_i[g]),
      .pend_o     (pend[g]),
      .pend_nxt_o (pend_nxt[g]),
      .live_nxt_o (live_nxt[g])
    );
  end

  irq_drive #(.NUM_SRC(NUM_SRC)) u_drv (
    .clk        (clk),
    .rst        (rst),
    .pend_nxt_i (pend_nxt),
    .live_nxt_i (live_nxt),
    .pull_o     (irq_pull_o)
  );

  assign psr_o = pend;

  // R9: line pulled low exactly while something is pending
  property p_irq_tracks_psr_r9;
    @(posedge clk) disable iff (rst)
      irq_pull_o == (psr_o != '0);
  endproperty
  assert property (p_irq_tracks_psr_r9);

  // R1: reset leaves the block idle
  property p_reset_idle_r1;
    @(posedge clk) rst |=> (psr_o == '0) && !irq_pull_o;
  endproperty
  assert property (p_reset_idle_r1);
endmodule

// File: tb/stat_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module stat_irq_ctrl_tb_top;
  logic       clk;
  logic       rst;
  logic [4:0] lvl;
  logic       ovf;
  logic       unf;
  logic       wr;
  logic [6:0] wdata;
  logic [6:0] psr;
  logic       irq;
  int         checks;
  int         errors;

  stat_irq_ctrl dut_i (
    .clk          (clk),
    .rst          (rst),
    .stat_lvl_i   (lvl),
    .ovf_stb_i    (ovf),
    .unf_stb_i    (unf),
    .host_wr_i    (wr),
    .host_wdata_i (wdata),
    .psr_o        (psr),
    .irq_pull_o   (irq)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [6:0] exp_psr,
                            input logic exp_irq);
    checks++;
    if (psr !== exp_psr || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s psr=%h irq=%b expected psr=%h irq=%b",
               req, psr, irq, exp_psr, exp_irq);
    end
  endtask

  task automatic host_write(input logic [6:0] v);
    wr = 1'b1;
    wdata = v;
    tick();
    wr = 1'b0;
    wdata = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1; lvl = 5'b10110; ovf = 0; unf = 0; wr = 0; wdata = '0;
    repeat (3) tick();
    expect_out("R1 in reset", 7'h00, 1'b0);
    rst = 1'b0;
    tick();
    expect_out("R1 after release", 7'h00, 1'b0);
    repeat (3) tick();
    expect_out("R10 static nonzero levels", 7'h00, 1'b0);
  endtask

  task automatic t_rise();
    lvl[0] = 1'b1;
    tick();
    expect_out("R2 rising flag0", 7'h01, 1'b1);
    tick();
    expect_out("R8 sticky flag0", 7'h01, 1'b1);
    host_write(7'h01);
    expect_out("R5 clear flag0", 7'h00, 1'b0);
    host_write(7'h00);
    expect_out("R5 unmask quiet", 7'h00, 1'b0);
  endtask

  task automatic t_fall();
    lvl[1] = 1'b0;
    tick();
    expect_out("R3 falling flag1", 7'h02, 1'b1);
    lvl[4] = 1'b0; lvl[3] = 1'b1;
    tick();
    expect_out("R3 two flags at once", 7'h1A, 1'b1);
    host_write(7'h1A);
    expect_out("R5 clear three", 7'h00, 1'b0);
    host_write(7'h00);
  endtask

  task automatic t_strobes();
    ovf = 1'b1;
    tick();
    ovf = 1'b0;
    expect_out("R4 overflow", 7'h20, 1'b1);
    unf = 1'b1;
    tick();
    unf = 1'b0;
    expect_out("R4 underflow", 7'h60, 1'b1);
    host_write(7'h20);
    expect_out("R8 partial clear keeps underflow", 7'h40, 1'b1);
    host_write(7'h40);
    expect_out("R5 clear underflow", 7'h00, 1'b0);
    host_write(7'h00);
  endtask

  task automatic t_mask();
    host_write(7'h24);
    lvl[2] = ~lvl[2];
    tick();
    expect_out("R6 masked flag2 toggle", 7'h00, 1'b0);
    ovf = 1'b1;
    tick();
    ovf = 1'b0;
    lvl[2] = ~lvl[2];
    tick();
    expect_out("R6 masked overflow", 7'h00, 1'b0);
    host_write(7'h00);
    tick();
    expect_out("R7 no memory of masked events", 7'h00, 1'b0);
    lvl[2] = ~lvl[2];
    tick();
    expect_out("R7 flag2 live again", 7'h04, 1'b1);
    ovf = 1'b1;
    tick();
    ovf = 1'b0;
    expect_out("R7 overflow live again", 7'h24, 1'b1);
    host_write(7'h24);
    host_write(7'h00);
    expect_out("R5 cleanup", 7'h00, 1'b0);
  endtask

  task automatic t_simul();
    wr = 1'b1; wdata = 7'h08; lvl[3] = ~lvl[3];
    tick();
    wr = 1'b0; wdata = '0;
    expect_out("R11 clear beats event", 7'h00, 1'b0);
    host_write(7'h00);
    tick();
    expect_out("R11 nothing after unmask", 7'h00, 1'b0);
    unf = 1'b1; wr = 1'b1; wdata = 7'h40;
    tick();
    unf = 1'b0; wr = 1'b0; wdata = '0;
    expect_out("R11 clear beats underflow", 7'h00, 1'b0);
    host_write(7'h00);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    t_reset();
    t_rise();
    t_fall();
    t_strobes();
    t_mask();
    t_simul();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule